// File: doc/BRIEF.md
# Five-Function 64-bit Arithmetic Unit

This block is the arithmetic stage of a simple datapath. It takes two 64-bit operands and a 3-bit operation code and produces one 64-bit result. It has no clock and holds no state: the result follows the operands and the code through combinational logic alone.

Three functional units run side by side:

- a shared adder that does both addition and subtraction;
- a 32x32 unsigned multiplier;
- a pair of logical barrel shifters, one left and one right.

A final selector passes one unit's output to the result port. For subtraction the adder receives the bitwise complement of the second operand and a carry-in of one. The multiplier uses only the lower half of each operand, so its full product fits the result width. The shifters take their distance from the low six bits of the second operand.

Arithmetic wraps modulo 2^64 and no overflow or carry is reported. Codes outside the five defined ones drive a zero result.

Top module: `fivefn_alu`

## Requirements
- R1: With op_sel = 3'b000, result equals opnd_a + opnd_b modulo 2^64; no overflow is indicated (all-ones plus one gives zero).
- R2: With op_sel = 3'b001, result equals opnd_a - opnd_b modulo 2^64 (zero minus one gives all ones, never an off-by-one value).
- R3: With op_sel = 3'b010, result equals the full 64-bit unsigned product of opnd_a[31:0] and opnd_b[31:0]; bits 63:32 of both operands have no effect on result.
- R4: With op_sel = 3'b011, result equals opnd_a shifted left by opnd_b[5:0] with zeros entering at bit 0; bits 63:6 of opnd_b have no effect.
- R5: With op_sel = 3'b100, result equals opnd_a shifted right logically by opnd_b[5:0] with zeros entering at bit 63; bits 63:6 of opnd_b have no effect.
- R6: With op_sel equal to 3'b101, 3'b110 or 3'b111, result is zero for any operands.
- R7: The block has no clock; result reflects the present opnd_a, opnd_b and op_sel without any clock edge.
- R8: With opnd_a = 7 and opnd_b = 3, the results are 10 (add), 4 (subtract), 21 (multiply), 56 (left shift) and 0 (right shift).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 64 | First operand |
| opnd_b | input | 64 | Second operand; its low 6 bits set the shift distance |
| op_sel | input | 3 | Operation code: 000 add, 001 subtract, 010 multiply, 011 left shift, 100 right shift |
| result | output | 64 | Selected unit's output |

## Verification
The block holds no state, so a fault inside it shows at the result port in the same evaluation that applies the inputs. There is no later cycle in which it can surface. The fault appears only under the operation code that selects the faulty unit.

A missing carry-in shows as every subtraction coming out one too small. A multiplier fed the wrong operand slice shows only when the upper operand halves are nonzero. A shifter stage wired to the wrong distance shows only for distances that have that bit set. The directed cases therefore pair each code with high-half noise, all-ones operands, and shift distances of 0, 1, 32 and 63.

// File: rtl/fivefn_alu_pkg.sv
package fivefn_alu_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 3'b000,
    OP_SUB = 3'b001,
    OP_MUL = 3'b010,
    OP_SHL = 3'b011,
    OP_SHR = 3'b100
  } alu_op_e;
endpackage

// File: rtl/fivefn_addsub.sv
module fivefn_addsub #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              subtract,
  output logic [DATA_W-1:0] sum
);
  // Complement B and inject carry-in one when subtracting.
  logic [DATA_W-1:0] b_eff;
  logic [DATA_W-1:0] cin_vec;

  assign b_eff   = b ^ {DATA_W{subtract}};
  assign cin_vec = {{(DATA_W-1){1'b0}}, subtract};
  assign sum     = a + b_eff + cin_vec;
endmodule

// File: rtl/fivefn_mul_half.sv
module fivefn_mul_half #(
  parameter int HALF_W = 32
) (
  input  logic [HALF_W-1:0]   a_lo,
  input  logic [HALF_W-1:0]   b_lo,
  output logic [2*HALF_W-1:0] prod
);
  localparam int PROD_W = 2 * HALF_W;

  logic [PROD_W-1:0] a_ext;
  logic [PROD_W-1:0] b_ext;

  assign a_ext = {{HALF_W{1'b0}}, a_lo};
  assign b_ext = {{HALF_W{1'b0}}, b_lo};
  assign prod  = a_ext * b_ext;
endmodule

// File: rtl/fivefn_shifter.sv
module fivefn_shifter #(
  parameter int DATA_W  = 64,
  parameter int SHAMT_W = $clog2(DATA_W),
  parameter bit LEFT    = 1'b1
) (
  input  logic [DATA_W-1:0]  din,
  input  logic [SHAMT_W-1:0] amt,
  output logic [DATA_W-1:0]  dout
);
  // Logarithmic barrel: stage k moves the word by 2**k when amt[k] is set.
  logic [DATA_W-1:0] stg [0:SHAMT_W];

  assign stg[0] = din;

  for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
    localparam int STEP = 1 << k;
    logic [DATA_W-1:0] moved;
    if (LEFT) begin : g_left
      assign moved = stg[k] << STEP;
    end else begin : g_right
      assign moved = stg[k] >> STEP;
    end
    assign stg[k+1] = amt[k] ? moved : stg[k];
  end

  assign dout = stg[SHAMT_W];
endmodule

// File: rtl/fivefn_result_mux.sv
module fivefn_result_mux
  import fivefn_alu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] arith,
  input  logic [DATA_W-1:0] prod,
  input  logic [DATA_W-1:0] shl,
  input  logic [DATA_W-1:0] shr,
  output logic [DATA_W-1:0] dout
);
  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB: dout = arith;
      OP_MUL:         dout = prod;
      OP_SHL:         dout = shl;
      OP_SHR:         dout = shr;
      default:        dout = '0;
    endcase
  end
endmodule

// File: rtl/fivefn_alu.sv
module fivefn_alu
  import fivefn_alu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [OP_W-1:0]   op_sel,
  output logic [DATA_W-1:0] result
);
  localparam int HALF_W  = DATA_W / 2;
  localparam int SHAMT_W = $clog2(DATA_W);

  logic [DATA_W-1:0] arith_res;
  logic [DATA_W-1:0] prod_res;
  logic [DATA_W-1:0] shl_res;
  logic [DATA_W-1:0] shr_res;
  logic              do_sub;
  logic              unused_b_hi;

  assign do_sub      = (op_sel == OP_SUB);
  assign unused_b_hi = ^opnd_b[DATA_W-1:SHAMT_W];

  fivefn_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a        (opnd_a),
    .b        (opnd_b),
    .subtract (do_sub),
    .sum      (arith_res)
  );

  fivefn_mul_half #(.HALF_W(HALF_W)) u_mul (
    .a_lo (opnd_a[HALF_W-1:0]),
    .b_lo (opnd_b[HALF_W-1:0]),
    .prod (prod_res)
  );

  fivefn_shifter #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W), .LEFT(1'b1)) u_shl (
    .din  (opnd_a),
    .amt  (opnd_b[SHAMT_W-1:0]),
    .dout (shl_res)
  );

  fivefn_shifter #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W), .LEFT(1'b0)) u_shr (
    .din  (opnd_a),
    .amt  (opnd_b[SHAMT_W-1:0]),
    .dout (shr_res)
  );

  fivefn_result_mux #(.DATA_W(DATA_W)) u_mux (
    .op    (op_sel),
    .arith (arith_res),
    .prod  (prod_res),
    .shl   (shl_res),
    .shr   (shr_res),
    .dout  (result)
  );
endmodule

// File: rtl/fivefn_alu_chk.sv
module fivefn_alu_chk #(
  parameter int DATA_W = 64
) (
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b,
  input logic [2:0]        op_sel,
  input logic [DATA_W-1:0] result
);
  localparam int HALF_W  = DATA_W / 2;
  localparam int SHAMT_W = $clog2(DATA_W);

  // The unit has no clock, so the checks are immediate and re-evaluate on every input change.
  always_comb begin
    if (op_sel == 3'b000 && opnd_b == '0)
      p_add_identity_r1: assert (result == opnd_a);
    if (op_sel == 3'b001 && opnd_a == opnd_b)
      p_sub_self_zero_r2: assert (result == '0);
    if (op_sel == 3'b010 && opnd_b[HALF_W-1:0] == HALF_W'(1))
      p_mul_by_one_r3: assert (result == {{HALF_W{1'b0}}, opnd_a[HALF_W-1:0]});
    if (op_sel == 3'b011 && opnd_b[SHAMT_W-1:0] == '0)
      p_shl_zero_dist_r4: assert (result == opnd_a);
    if (op_sel == 3'b100 && opnd_b[SHAMT_W-1:0] != '0)
      p_shr_msb_clear_r5: assert (result[DATA_W-1] == 1'b0);
    if (op_sel > 3'b100)
      p_unused_code_zero_r6: assert (result == '0);
  end
endmodule

bind fivefn_alu fivefn_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .opnd_a (opnd_a),
  .opnd_b (opnd_b),
  .op_sel (op_sel),
  .result (result)
);

// File: tb/fivefn_alu_tb_top.sv
module fivefn_alu_tb_top;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic [W-1:0] a;
  logic [W-1:0] b;
  logic [2:0]   op;
  logic [W-1:0] r;
  int           checks = 0;
  int           errors = 0;
  int           cycles = 0;
  bit           done   = 1'b0;

  always #5 clk = ~clk;

  fivefn_alu #(.DATA_W(W)) dut_i (
    .opnd_a (a),
    .opnd_b (b),
    .op_sel (op),
    .result (r)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog R7: actual=%0d cycles expected<100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [W-1:0] model(input logic [2:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W-1:0] xl;
    logic [W-1:0] yl;
    xl = {32'd0, x[31:0]};
    yl = {32'd0, y[31:0]};
    case (o)
      3'b000:  return x + y;
      3'b001:  return x - y;
      3'b010:  return xl * yl;
      3'b011:  return x << y[5:0];
      3'b100:  return x >> y[5:0];
      default: return '0;
    endcase
  endfunction

  task automatic apply_check(input string tag, input logic [2:0] o,
                             input logic [W-1:0] x, input logic [W-1:0] y,
                             input logic [W-1:0] exp);
    @(negedge clk);
    a  = x;
    b  = y;
    op = o;
    #1;
    checks++;
    if (r !== exp) begin
      errors++;
      $display("FAIL %s op=%b a=%h b=%h: actual=%h expected=%h", tag, o, x, y, r, exp);
    end
  endtask

  task automatic t_idle_zero;
    // R1: all-zero inputs on the add code give zero
    apply_check("R1 idle", 3'b000, '0, '0, '0);
  endtask

  task automatic t_worked_example;
    apply_check("R8 add", 3'b000, 64'd7, 64'd3, 64'd10);
    apply_check("R8 sub", 3'b001, 64'd7, 64'd3, 64'd4);
    apply_check("R8 mul", 3'b010, 64'd7, 64'd3, 64'd21);
    apply_check("R8 shl", 3'b011, 64'd7, 64'd3, 64'd56);
    apply_check("R8 shr", 3'b100, 64'd7, 64'd3, 64'd0);
  endtask

  task automatic t_add;
    apply_check("R1 wrap", 3'b000, '1, 64'd1, '0);
    apply_check("R1 ones", 3'b000, '1, '1, {{63{1'b1}}, 1'b0});
    for (int i = 0; i < 20; i++) begin
      logic [W-1:0] x;
      logic [W-1:0] y;
      x = {$urandom, $urandom};
      y = {$urandom, $urandom};
      apply_check("R1 rand", 3'b000, x, y, model(3'b000, x, y));
    end
  endtask

  task automatic t_sub;
    apply_check("R2 borrow", 3'b001, '0, 64'd1, '1);
    apply_check("R2 self", 3'b001, 64'h0123_4567_89ab_cdef, 64'h0123_4567_89ab_cdef, '0);
    apply_check("R2 ones", 3'b001, '1, '1, '0);
    for (int i = 0; i < 20; i++) begin
      logic [W-1:0] x;
      logic [W-1:0] y;
      x = {$urandom, $urandom};
      y = {$urandom, $urandom};
      apply_check("R2 rand", 3'b001, x, y, model(3'b001, x, y));
    end
  endtask

  task automatic t_mul;
    apply_check("R3 max", 3'b010, '1, '1, 64'hFFFF_FFFE_0000_0001);
    apply_check("R3 hi ignored", 3'b010, 64'hDEAD_BEEF_0000_0005, 64'h1234_5678_0000_0006, 64'd30);
    for (int i = 0; i < 20; i++) begin
      logic [W-1:0] x;
      logic [W-1:0] y;
      x = {$urandom, $urandom};
      y = {$urandom, $urandom};
      apply_check("R3 rand", 3'b010, x, y, model(3'b010, x, y));
    end
  endtask

  task automatic t_shifts;
    logic [W-1:0] pat;
    pat = 64'h8000_0000_0000_0001;
    apply_check("R4 dist0", 3'b011, pat, 64'd0, pat);
    apply_check("R4 dist63", 3'b011, '1, 64'd63, 64'h8000_0000_0000_0000);
    apply_check("R4 dist32", 3'b011, pat, 64'd32, 64'h0000_0001_0000_0000);
    apply_check("R4 b hi ignored", 3'b011, pat, 64'hFFFF_FFFF_FFFF_FFC1, 64'd2);
    apply_check("R5 dist0", 3'b100, pat, 64'd0, pat);
    apply_check("R5 dist63", 3'b100, '1, 64'd63, 64'd1);
    apply_check("R5 zero fill", 3'b100, '1, 64'd1, {1'b0, {63{1'b1}}});
    apply_check("R5 b hi ignored", 3'b100, pat, 64'hABCD_0000_0000_0040, pat);
    for (int i = 0; i < 64; i++) begin
      logic [W-1:0] x;
      x = {$urandom, $urandom};
      apply_check("R4 sweep", 3'b011, x, W'(i), x << i);
      apply_check("R5 sweep", 3'b100, x, W'(i), x >> i);
    end
  endtask

  task automatic t_unused;
    for (int o = 5; o < 8; o++) begin
      apply_check("R6 ones", 3'(o), '1, '1, '0);
      apply_check("R6 pat", 3'(o), 64'd7, 64'd3, '0);
    end
  endtask

  task automatic t_no_clock;
    // R7: result follows inputs mid-cycle with no clock edge in between
    @(negedge clk);
    a  = 64'd100;
    b  = 64'd5;
    op = 3'b000;
    #1;
    checks++;
    if (r !== 64'd105) begin
      errors++;
      $display("FAIL R7 first: actual=%h expected=%h", r, 64'd105);
    end
    op = 3'b001;
    #1;
    checks++;
    if (r !== 64'd95) begin
      errors++;
      $display("FAIL R7 op change: actual=%h expected=%h", r, 64'd95);
    end
    b = 64'd2;
    op = 3'b011;
    #1;
    checks++;
    if (r !== 64'd400) begin
      errors++;
      $display("FAIL R7 operand change: actual=%h expected=%h", r, 64'd400);
    end
  endtask

  initial begin
    a  = '0;
    b  = '0;
    op = 3'b000;
    t_idle_zero();
    t_worked_example();
    t_add();
    t_sub();
    t_mul();
    t_shifts();
    t_unused();
    t_no_clock();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule